// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station side of a two-wire PHY management link. A host asks for one transaction with a single-cycle request that carries the direction, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then builds the serial frame on the management clock (`mdc`) and on the data line. The data line is split into a driven value, an output enable for the pad tristate, and a sampled input. When the frame is over, the block raises a one-cycle completion pulse. On a read it shows the 16-bit register value at the same moment.

Every serial bit is built from clock phases, and each phase lasts a parameter-set number of system clocks. A bit that the block drives uses three phases: clock low, clock high, clock low, with the data unchanged through all three. A read frame needs a turnaround. There the block releases the line for one three-phase slot and then takes in 16 bits. Each of those bits is a high phase, during which the line is sampled, followed by a low phase. A write frame drives its turnaround bits itself. It then finishes with one low, non-driving phase before it reports completion. A request that arrives while a frame is in progress is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Every frame begins with 32 driven bits, all equal to one.
- R2: After the ones come the start bits 0 then 1, then the operation bits: 1,0 for a read and 0,1 for a write (leftmost bit sent first).
- R3: Next come the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first.
- R4: A write continues with the driven turnaround bits 1 then 0, then the 16 data bits MSB first, for 64 driven bits in total.
- R5: A read releases the line for one slot (low, high, low) and then takes 16 bits MSB first. Each bit is sampled while `mdc` is high. The assembled word appears on `rd_data` in the cycle `done` is high and holds until the next read completes.
- R6: A driven bit keeps its value through its low, high and trailing low phases.
- R7: Each clock phase lasts exactly PHASE_CYCLES system clocks. A read keeps `busy` high for 173 phases and a write for 193 phases.
- R8: A write ends with exactly one phase in which `mdc` is low and the line is not driven.
- R9: `mdio_oe` is high only while frame bits are driven. A read has 46 driven bits, 35 undriven phases and 63 rising edges of `mdc`. A write has 64 rising edges.
- R10: `done` is a single-cycle pulse, and `busy` is low in that cycle.
- R11: A request that arrives while `busy` is high is ignored. It changes no bit of the current frame and starts no later frame.
- R12: After reset, `busy`, `done`, `mdc` and `mdio_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Single-cycle request strobe, taken when not busy |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | ADDR_W | PHY address |
| req_reg | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last read word, valid with done after a read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Driven data value |
| mdio_oe | output | 1 | Tristate enable for the data line |
| mdio_i | input | 1 | Sampled data line |

## Verification
The bench sets PHASE_CYCLES to 3. That value is not a power of two, so every wrap of the phase counter is exercised, and each frame is short enough that several reads and writes fit in the run. The field widths stay at their defaults of 32, 5 and 16, so the bit counts and phase counts match real frames exactly. A phase length of 3 also gives the bench room to place the PHY's read bits between the falling edges of `mdc`, and to inject a request part-way through a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_RELEASE,
    ST_SAMPLE,
    ST_TAIL
  } mdio_state_e;

  localparam logic [1:0] SOF_BITS  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_DRIVEN = 2'b10;

  localparam logic [1:0] PH_FIRST_LOW = 2'd0;
  localparam logic [1:0] PH_HIGH      = 2'd1;
  localparam logic [1:0] PH_LAST_LOW  = 2'd2;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int PHASE_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  // Counter parks at zero between frames so the first phase is full length.
  always_comb begin
    if (!run || cnt_q == LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
#(
  parameter int PRE_W   = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = PRE_W + 4 + 2*ADDR_W + 2 + DATA_W,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] rg,
  input  logic [DATA_W-1:0] wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  localparam int RD_BITS = PRE_W + 4 + 2*ADDR_W;

  // Frame is left-aligned: the bit sent first sits at the MSB.
  always_comb begin
    if (wr) begin
      frame = {{PRE_W{1'b1}}, SOF_BITS, OP_WRITE, phy, rg, TA_DRIVEN, wdata};
      nbits = CNT_W'(FRAME_W);
    end else begin
      frame = {{PRE_W{1'b1}}, SOF_BITS, OP_READ, phy, rg, {(2 + DATA_W){1'b0}}};
      nbits = CNT_W'(RD_BITS);
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic               start_wr,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe
);
  mdio_state_e        state_q, state_d;
  logic [1:0]         ph_q, ph_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic               wr_q, wr_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic [DATA_W-1:0]  rd_q, rd_d;
  logic               done_q, done_d;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    sh_d    = sh_q;
    left_d  = left_q;
    wr_d    = wr_q;
    rx_d    = rx_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_DRIVE;
          ph_d    = PH_FIRST_LOW;
          sh_d    = frame_in;
          left_d  = nbits_in;
          wr_d    = start_wr;
        end
      end
      ST_DRIVE: begin
        if (tick) begin
          if (ph_q == PH_LAST_LOW) begin
            ph_d   = PH_FIRST_LOW;
            sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
            left_d = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) state_d = wr_q ? ST_TAIL : ST_RELEASE;
          end else begin
            ph_d = ph_q + 2'd1;
          end
        end
      end
      ST_RELEASE: begin
        if (tick) begin
          if (ph_q == PH_LAST_LOW) begin
            ph_d    = 2'd0;
            state_d = ST_SAMPLE;
            left_d  = CNT_W'(DATA_W);
          end else begin
            ph_d = ph_q + 2'd1;
          end
        end
      end
      ST_SAMPLE: begin
        // ph 0 = clock high (sample at its end), ph 1 = clock low
        if (tick) begin
          if (ph_q == 2'd0) begin
            rx_d = {rx_q[DATA_W-2:0], mdio_i};
            ph_d = 2'd1;
          end else begin
            ph_d   = 2'd0;
            left_d = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              rd_d    = rx_q;
            end
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      sh_q    <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      rx_q    <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      wr_q    <= wr_d;
      rx_q    <= rx_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign rd_data = rd_q;
  assign mdio_oe = (state_q == ST_DRIVE);
  assign mdio_o  = mdio_oe && sh_q[FRAME_W-1];
  assign mdc     = ((state_q == ST_DRIVE || state_q == ST_RELEASE) && ph_q == PH_HIGH)
                || (state_q == ST_SAMPLE && ph_q == 2'd0);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int PHASE_CYCLES = 50,  // ~1 us per phase at 50 MHz
  parameter int PRE_W        = 32,
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_W = PRE_W + 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic               accept;
  logic               tick;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign accept = req_valid && !busy;

  mdio_frame_build #(
    .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_build (
    .wr(req_write), .phy(req_phy), .rg(req_reg), .wdata(req_wdata),
    .frame(frame), .nbits(nbits)
  );

  mdio_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run(busy), .tick(tick)
  );

  mdio_frame_seq #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .tick(tick),
    .start(accept), .start_wr(req_write), .frame_in(frame), .nbits_in(nbits),
    .mdio_i(mdio_i), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  // R9 / R12: nothing driven and no clock outside a frame
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  // R10: completion is one cycle wide and never overlaps busy
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: a driven bit survives the rise and the fall of mdc
  p_hold_into_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && !mdc) |=> (mdc -> $stable(mdio_o)));
  p_hold_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && mdc) |=> (mdio_oe && $stable(mdio_o)));

  // R5: read word only moves when completion is signalled
  p_rd_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done || $stable(rd_data)));

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_data(rd_data),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int P = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [4:0]  req_phy;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wdata;
    logic [15:0] word;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] cur_phy_word;
  int          n_chk, n_fail, issued, finished;
  bit          ended;

  mdio_mgmt_master #(.PHASE_CYCLES(P)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: waits for an idle master, issues one request, records the expectation
  task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] word);
    exp_t e;
    while (busy) @(negedge clk);
    e.wr = wr; e.phy = phy; e.rg = rg; e.wdata = wd; e.word = word;
    exp_q.push_back(e);
    cur_phy_word = word;
    issued++;
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor plus PHY model
  initial begin
    logic [63:0] cap;
    int nd, bcyc, ucyc, rises, viol, falls;
    bit prev_mdc, prev_busy, prev_oe, prev_o, prev_done;
    exp_t e;
    cap = '0; nd = 0; bcyc = 0; ucyc = 0; rises = 0; viol = 0; falls = 0;
    prev_mdc = 0; prev_busy = 0; prev_oe = 0; prev_o = 0; prev_done = 0;
    mdio_i = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_done) check(!done, "R10 done width", done, 0);
      if (busy && !prev_busy) begin
        cap = '0; nd = 0; bcyc = 0; ucyc = 0; rises = 0; viol = 0; falls = 0;
        mdio_i = ~cur_phy_word[15];
      end
      if (busy) begin
        bcyc++;
        if (!mdio_oe) ucyc++;
        if (mdc && !prev_mdc) begin
          rises++;
          if (mdio_oe) begin cap = {cap[62:0], mdio_o}; nd++; end
        end
        if (mdio_oe && prev_oe && (mdio_o != prev_o) && (mdc || prev_mdc)) viol++;
        if (!mdio_oe && prev_mdc && !mdc) begin
          falls++;
          if (falls <= 16) mdio_i = cur_phy_word[16 - falls];
          else             mdio_i = ~mdio_i;
        end
      end
      if (done) begin
        finished++;
        check(!busy, "R10 busy low with done", busy, 0);
        if (exp_q.size() == 0) begin
          check(0, "R11 unexpected frame", finished, issued);
        end else begin
          e = exp_q.pop_front();
          check(nd == (e.wr ? 64 : 46), "R9 driven bit count", nd, e.wr ? 64 : 46);
          if (nd >= 46) begin
            check(cap[nd-1 -: 32] == 32'hFFFF_FFFF, "R1 preamble", cap[nd-1 -: 32], 32'hFFFF_FFFF);
            check(cap[nd-33 -: 4] == {2'b01, (e.wr ? 2'b01 : 2'b10)}, "R2 start/op",
                  cap[nd-33 -: 4], {2'b01, (e.wr ? 2'b01 : 2'b10)});
            check(cap[nd-37 -: 10] == {e.phy, e.rg}, "R3 phy/reg address",
                  cap[nd-37 -: 10], {e.phy, e.rg});
          end
          check(viol == 0, "R6 driven bit stability", viol, 0);
          check(bcyc == (e.wr ? 193 : 173) * P, "R7 frame length", bcyc, (e.wr ? 193 : 173) * P);
          if (e.wr) begin
            check(cap[17:0] == {2'b10, e.wdata}, "R4 turnaround+data", cap[17:0], {2'b10, e.wdata});
            check(ucyc == P, "R8 tail release", ucyc, P);
            check(rises == 64, "R9 write mdc rises", rises, 64);
          end else begin
            check(rd_data == e.word, "R5 read data", rd_data, e.word);
            check(ucyc == 35 * P, "R9 read undriven cycles", ucyc, 35 * P);
            check(rises == 63, "R9 read mdc rises", rises, 63);
          end
        end
      end
      prev_done = done; prev_mdc = mdc; prev_busy = busy;
      prev_oe = mdio_oe; prev_o = mdio_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; issued = 0; finished = 0; ended = 0;
    cur_phy_word = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_phy = '0; req_reg = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(!busy && !done, "R12 busy/done after reset", {busy, done}, 0);
    check(!mdc && !mdio_oe, "R12 mdc/oe after reset", {mdc, mdio_oe}, 0);

    issue(1'b0, 5'h01, 5'h00, 16'h0000, 16'hA5C3);
    wait_idle();
    issue(1'b1, 5'h1F, 5'h15, 16'h8001, 16'h0000);
    wait_idle();
    check(rd_data == 16'hA5C3, "R5 rd_data held over write", rd_data, 16'hA5C3);

    // R11: a request while busy must be dropped
    issue(1'b1, 5'h0A, 5'h0A, 16'h1234, 16'h0000);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h15; req_reg = 5'h03; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    check(!busy, "R11 no frame from dropped request", busy, 0);
    check(finished == issued, "R11 frame count", finished, issued);

    // back-to-back requests and extreme data patterns
    issue(1'b0, 5'h10, 5'h1F, 16'h0000, 16'h0001);
    issue(1'b0, 5'h00, 5'h01, 16'h0000, 16'hFFFF);
    issue(1'b1, 5'h00, 5'h00, 16'h0000, 16'h0000);
    issue(1'b0, 5'h15, 5'h0A, 16'h0000, 16'h8000);
    wait_idle();
    repeat (6) @(negedge clk);
    check(finished == issued, "R11 total frames", finished, issued);
    check(!busy && !mdio_oe && !mdc, "R9 idle after frames", {busy, mdio_oe, mdc}, 0);
    finish_run();
  end

endmodule